// File: doc/BRIEF.md
# Addressable Serial Nibble Receiver

This block listens on a single asynchronous serial line that is shared by up to eight identical receivers. Every 8-N-1 frame on that line carries a marker bit, a 3-bit device address and a 4-bit nibble. Each receiver has its own address set by three strap inputs. It ignores every frame addressed to another device and every frame whose marker bit is clear.

Two accepted frames make one byte. The first supplies the low nibble and the second the high nibble. When the second nibble arrives, the 8-bit output updates and an active-low strobe pulses for one bit time. A host can therefore write parallel bytes to several independent targets, such as a data latch, an address latch or a control latch, over one wire.

The byte can also be presented on a bus that is gated by an output-enable input. The tri-state is modelled as a separate enable output. The bit period is set by the parameter `CLKS_PER_BIT`.

Top module: `nibble_addr_rx`

## Requirements
- R1: The line idles high. A frame is a low start bit, 8 data bits sent LSB first, and a high stop bit, with no parity. The start bit is confirmed by sampling it again half a bit after the falling edge. A low pulse shorter than half a bit starts no frame.
- R2: Data bit 0 of a frame must be 1. A frame with bit 0 at 0 is discarded and leaves the nibble phase unchanged.
- R3: A frame is accepted only when data bits [3:1] equal `strap_i`. Frames carrying any other address are ignored.
- R4: Data bits [7:4] of an accepted frame are its nibble. The first accepted frame after reset or after a completed byte gives `byte_o[3:0]`. The next accepted frame gives `byte_o[7:4]`.
- R5: `byte_o` changes only when the second nibble of a pair is accepted. Accepting the first nibble leaves it unchanged.
- R6: Each completed byte drives `strobe_no` low for exactly `CLKS_PER_BIT` clock cycles, starting on the cycle that `byte_o` updates. At all other times `strobe_no` is high.
- R7: A frame whose stop bit samples low is dropped. It changes neither `byte_o` nor the nibble phase.
- R8: While `oe_i` is 1, `bus_en_o` is 1 and `bus_o` equals `byte_o`. While `oe_i` is 0, `bus_en_o` is 0 and `bus_o` is 0.
- R9: Reset sets `byte_o` to 0x00 and `strobe_no` to 1, and makes the next accepted frame a low nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Shared serial line, idles high |
| strap_i | input | 3 | This receiver's device address |
| oe_i | input | 1 | Output enable for the bus copy |
| byte_o | output | 8 | Last assembled byte |
| bus_o | output | 8 | Byte gated by `oe_i` (0 when disabled) |
| bus_en_o | output | 1 | Bus drive enable, models the tri-state |
| strobe_no | output | 1 | Active-low strobe, one bit time per byte |

## Verification
The assertions assume that complete bytes arrive no closer together than one bit time. On a real line this always holds, because a byte takes two frames of ten bits each. The strobe-width property relies on that spacing. The stimulus always sends whole frames at the exact bit period, then leaves at least three idle bit times before the next frame. The straps are changed only while the line is idle, so no frame is ever judged against two different addresses.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
    localparam int FRAME_BITS = 8;
    localparam int NIB_W      = 4;
    localparam int DEV_ADDR_W = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nrx_frame.sv
module nrx_frame
    import nrx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  rx_i,
    output logic                  frame_vld_o,
    output logic [FRAME_BITS-1:0] frame_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        rx_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  vld;
    } frm_t;

    frm_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        unique case (s_q.st)
            RX_IDLE: begin
                if (!rx_i) begin
                    s_d.st  = RX_START;
                    s_d.cnt = '0;
                end
            end
            RX_START: begin
                if (s_q.cnt == HALF_LAST) begin
                    s_d.cnt = '0;
                    s_d.idx = '0;
                    s_d.st  = rx_i ? RX_IDLE : RX_DATA;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (s_q.cnt == BIT_LAST) begin
                    s_d.cnt = '0;
                    s_d.sh  = {rx_i, s_q.sh[FRAME_BITS-1:1]};
                    s_d.idx = s_q.idx + 1'b1;
                    if (s_q.idx == IDX_LAST) s_d.st = RX_STOP;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (s_q.cnt == BIT_LAST) begin
                    s_d.cnt = '0;
                    s_d.vld = rx_i;
                    s_d.st  = RX_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0, vld: 1'b0};
        else         s_q <= s_d;
    end

    assign frame_vld_o = s_q.vld;
    assign frame_o     = s_q.sh;
endmodule

// File: rtl/nrx_assemble.sv
module nrx_assemble
    import nrx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  frame_vld_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [DEV_ADDR_W-1:0] strap_i,
    output logic [2*NIB_W-1:0]    byte_o,
    output logic                  strobe_no
);
    localparam int SC_W = $clog2(CLKS_PER_BIT + 1);
    localparam logic [SC_W-1:0] STRB_LEN = SC_W'(CLKS_PER_BIT);

    typedef struct packed {
        logic                 hi_next;
        logic [NIB_W-1:0]     lo;
        logic [2*NIB_W-1:0]   byte_v;
        logic [SC_W-1:0]      scnt;
    } asm_t;

    asm_t s_q, s_d;
    logic             tag_ok;
    logic             addr_hit;
    logic             take;
    logic [NIB_W-1:0] nib;

    always_comb begin
        tag_ok   = frame_i[0];
        addr_hit = frame_i[DEV_ADDR_W:1] == strap_i;
        nib      = frame_i[FRAME_BITS-1:FRAME_BITS-NIB_W];
        take     = frame_vld_i && tag_ok && addr_hit;

        s_d = s_q;
        if (s_q.scnt != '0) s_d.scnt = s_q.scnt - 1'b1;
        if (take) begin
            if (!s_q.hi_next) begin
                s_d.lo      = nib;
                s_d.hi_next = 1'b1;
            end else begin
                s_d.byte_v  = {nib, s_q.lo};
                s_d.hi_next = 1'b0;
                s_d.scnt    = STRB_LEN;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{hi_next: 1'b0, lo: '0, byte_v: '0, scnt: '0};
        else         s_q <= s_d;
    end

    assign byte_o    = s_q.byte_v;
    assign strobe_no = (s_q.scnt == '0);
endmodule

// File: rtl/nibble_addr_rx.sv
module nibble_addr_rx
    import nrx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  rxd_i,
    input  logic [DEV_ADDR_W-1:0] strap_i,
    input  logic                  oe_i,
    output logic [2*NIB_W-1:0]    byte_o,
    output logic [2*NIB_W-1:0]    bus_o,
    output logic                  bus_en_o,
    output logic                  strobe_no
);
    logic                  rx_s;
    logic                  frm_vld;
    logic [FRAME_BITS-1:0] frm;

    nrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (rxd_i),
        .q_o   (rx_s)
    );

    nrx_frame #(.CLKS_PER_BIT(CLKS_PER_BIT)) frame_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_i       (rx_s),
        .frame_vld_o(frm_vld),
        .frame_o    (frm)
    );

    nrx_assemble #(.CLKS_PER_BIT(CLKS_PER_BIT)) asm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .frame_vld_i(frm_vld),
        .frame_i    (frm),
        .strap_i    (strap_i),
        .byte_o     (byte_o),
        .strobe_no  (strobe_no)
    );

    assign bus_en_o = oe_i;
    assign bus_o    = oe_i ? byte_o : '0;
endmodule

// File: rtl/nibble_addr_rx_checks.sv
module nibble_addr_rx_checks #(
    parameter int CLKS_PER_BIT = 16
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       oe_i,
    input logic [7:0] byte_o,
    input logic [7:0] bus_o,
    input logic       bus_en_o,
    input logic       strobe_no
);
    localparam int LC_W = $clog2(CLKS_PER_BIT + 2);
    logic [LC_W-1:0] low_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         low_cnt <= '0;
        else if (!strobe_no) low_cnt <= low_cnt + 1'b1;
        else                 low_cnt <= '0;
    end

    p_strobe_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_cnt <= LC_W'(CLKS_PER_BIT));

    p_strobe_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(strobe_no) |-> low_cnt == LC_W'(CLKS_PER_BIT));

    p_byte_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(byte_o) |-> $fell(strobe_no));

    p_bus_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_i |-> (bus_o == 8'h00 && !bus_en_o));

    p_bus_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_i |-> (bus_o == byte_o && bus_en_o));
endmodule

bind nibble_addr_rx nibble_addr_rx_checks #(.CLKS_PER_BIT(CLKS_PER_BIT)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oe_i     (oe_i),
    .byte_o   (byte_o),
    .bus_o    (bus_o),
    .bus_en_o (bus_en_o),
    .strobe_no(strobe_no)
);

// File: tb/nibble_addr_rx_tb_top.sv
`timescale 1ns/1ps
module nibble_addr_rx_tb_top;
    localparam int CPB = 16;
    localparam int NV  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] strap = 3'd5;
    logic       oe = 1'b0;
    logic [7:0] byte_w, bus_w;
    logic       bus_en_w, strobe_w;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int last_width = 0;
    int run = 0;
    int cycles = 0;
    logic prev_strb = 1'b1;

    always #2 clk = ~clk;

    nibble_addr_rx #(.CLKS_PER_BIT(CPB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .strap_i(strap), .oe_i(oe),
        .byte_o(byte_w), .bus_o(bus_w), .bus_en_o(bus_en_w), .strobe_no(strobe_w)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!strobe_w) run <= run + 1;
        if (strobe_w && !prev_strb) begin
            pulses     <= pulses + 1;
            last_width <= run;
            run        <= 0;
        end
        prev_strb <= strobe_w;
    end

    // {frame, expected byte after it, expected strobe pulse}, strap = 5
    localparam logic [16:0] VEC [NV] = '{
        {8'h3B, 8'h00, 1'b0},
        {8'hAB, 8'hA3, 1'b1},
        {8'h5D, 8'hA3, 1'b0},
        {8'h7A, 8'hA3, 1'b0},
        {8'hFB, 8'hA3, 1'b0},
        {8'h49, 8'hA3, 1'b0},
        {8'h0B, 8'h0F, 1'b1},
        {8'h1B, 8'h0F, 1'b0},
        {8'h1A, 8'h0F, 1'b0},
        {8'hEB, 8'hE1, 1'b1}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] f, input logic stop_ok);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(f[i]);
        bit_time(stop_ok);
        bit_time(1'b1);
        bit_time(1'b1);
        bit_time(1'b1);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset byte", byte_w, 8'h00);
        chk("R9 reset strobe", strobe_w, 1'b1);
        chk("R8 bus disabled en", bus_en_w, 1'b0);
        chk("R8 bus disabled value", bus_w, 8'h00);

        for (int k = 0; k < NV; k++) begin
            p0 = pulses;
            send(VEC[k][16:9], 1'b1);
            chk($sformatf("R5 table row %0d byte", k), byte_w, VEC[k][8:1]);
            chk($sformatf("R6 table row %0d pulses", k), pulses - p0, VEC[k][0]);
        end
        chk("R6 strobe width", last_width, CPB);

        oe = 1'b1;
        @(negedge clk);
        chk("R8 bus copy", bus_w, 8'hE1);
        chk("R8 bus enable", bus_en_w, 1'b1);
        oe = 1'b0;
        @(negedge clk);
        chk("R8 bus released", bus_w, 8'h00);

        // R7: bad stop bit dropped, phase kept
        p0 = pulses;
        send(8'h2B, 1'b1);
        send(8'h9B, 1'b0);
        chk("R7 bad stop no change", byte_w, 8'hE1);
        send(8'h6B, 1'b1);
        chk("R7 byte after dropped frame", byte_w, 8'h62);
        chk("R7 one pulse", pulses - p0, 1);

        // R1: short glitch starts no frame
        p0 = pulses;
        send(8'hCB, 1'b1);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * CPB) @(negedge clk);
        chk("R1 glitch ignored", byte_w, 8'h62);
        send(8'h7B, 1'b1);
        chk("R1 byte after glitch", byte_w, 8'h7C);
        chk("R1 glitch pulses", pulses - p0, 1);

        // R9/R4: reset clears phase
        send(8'h4B, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 byte cleared mid pair", byte_w, 8'h00);
        send(8'h8B, 1'b1);
        chk("R4 first after reset is low", byte_w, 8'h00);
        send(8'h1B, 1'b1);
        chk("R4 byte after reset", byte_w, 8'h18);

        // R3: other strap value
        strap = 3'd6;
        @(negedge clk);
        send(8'h5D, 1'b1);
        send(8'h7B, 1'b1);
        chk("R3 foreign address ignored", byte_w, 8'h18);
        send(8'h3D, 1'b1);
        chk("R3 new strap byte", byte_w, 8'h35);
        chk("R2 strobe idle high", strobe_w, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule